// File: doc/BRIEF.md
# Per-Channel Control Bit Serializer

This block sends one control bit per switched channel out on a single serial line that runs at twice the stream bit rate. A 512-entry array holds one control bit for each stream/channel pair (16 streams of 32 channels). Once per frame the block reads every entry through a one-bit read port and shifts the bits out, so that an external device can act on each channel individually.

The output is interleaved by channel rather than by stream. One channel time is 16 clocks, and during that time the block sends the bits of all 16 streams for one channel, with stream 0 first. The bits always lead the serial streams by one channel time: during channel c the line carries the bits that belong to channel (c+1) mod 32. As a result, the bit for stream 0, channel 0 goes out on the first clock of channel 31 of the previous frame.

The array read is registered. The address for a frame position is presented one clock before that position's bit appears on the output, so the output changes only on a clock edge. A frame pulse sets the position counter back to the start of the frame. Between pulses the counter wraps by itself every 512 clocks.

Top module: `ctrl_bit_serializer`

## Requirements
- R1: While rst_n is low, ser_out is 0 and rd_addr holds 1, which is the array address of frame position 0.
- R2: At a clock edge that samples frame_pulse high, the frame position becomes 0 and rd_addr becomes 1. On the next edge, ser_out takes the bit of frame position 0.
- R3: Frame position p = 16*c + k stands for clock k (0..15) of channel time c (0..31). Its bit is the array entry at address k*32 + ((c+1) mod 32), which is stream k and channel (c+1) mod 32.
- R4: Array address 0 (stream 0, channel 0) is emitted at frame position 496, the first clock of channel 31. Address 32 (stream 1, channel 0) is emitted at position 497.
- R5: The frame position advances by one on each clock and wraps from 511 to 0 with no frame pulse. Each frame therefore carries exactly 512 bits, and every array address is read once per frame.
- R6: rd_addr changes only on clock edges. When rd_addr shows the address for position p, ser_out shows the bit of position p-1. The bit of position p appears on ser_out one clock after its address.
- R7: A frame pulse sampled in the middle of a frame restarts the sequence at position 0 on that same edge. The bit whose address was already presented is still output.
- R8: A frame pulse that falls exactly on the 512-clock boundary leaves the output sequence unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, two clocks per stream bit |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_pulse | input | 1 | High for one clock; the edge that samples it starts a new frame |
| rd_addr | output | 9 | Registered read address into the control-bit array (stream*32 + channel) |
| rd_bit | input | 1 | Control bit at rd_addr, read combinationally |
| ser_out | output | 1 | Serial control bit stream |

## Verification
The bench loads the array with pseudo-random patterns and checks every output bit and every address over two full frames. A design that swapped the stream and channel fields, or that omitted the one-channel lead, fails on almost every position. A second test loads an array that is zero except at addresses 0 and 32, which pins those bits to the first two clocks of channel 31; a design off by one clock or by one channel places them elsewhere. Frame pulses are sent both in the middle of a frame and exactly on the wrap boundary. A design that dropped the in-flight bit, delayed the restart, or slipped a clock on an aligned pulse breaks the expected sequence.

// File: rtl/cbs_pkg.sv
package cbs_pkg;
  localparam int unsigned DEF_STREAMS  = 16;
  localparam int unsigned DEF_CHANNELS = 32;
  localparam int unsigned DEF_LEAD     = 1;
endpackage

// File: rtl/cbs_frame_counter.sv
module cbs_frame_counter #(
  parameter int unsigned SLOTS = 512,
  parameter int unsigned PW    = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_pulse,
  output logic [PW-1:0] pos_q,
  output logic [PW-1:0] pos_nxt
);
  localparam logic [PW-1:0] LAST = PW'(SLOTS - 1);

  always_comb begin
    if (frame_pulse)        pos_nxt = '0;
    else if (pos_q == LAST) pos_nxt = '0;
    else                    pos_nxt = pos_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pos_q <= '0;
    else        pos_q <= pos_nxt;
  end

  // R5: the frame wraps by itself when no pulse arrives
  p_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pos_q == LAST && !frame_pulse) |=> (pos_q == '0));
endmodule

// File: rtl/cbs_addr_stage.sv
module cbs_addr_stage #(
  parameter int unsigned STREAMS  = 16,
  parameter int unsigned CHANNELS = 32,
  parameter int unsigned LEAD     = 1
) (
  input  logic                                            clk,
  input  logic                                            rst_n,
  input  logic [$clog2(STREAMS)+$clog2(CHANNELS)-1:0]     pos_nxt,
  output logic [$clog2(STREAMS)+$clog2(CHANNELS)-1:0]     rd_addr
);
  localparam int unsigned SW = $clog2(STREAMS);
  localparam int unsigned CW = $clog2(CHANNELS);
  localparam int unsigned PW = SW + CW;

  // Position p = channel*STREAMS + stream maps to stream*CHANNELS + (channel+LEAD)
  function automatic logic [PW-1:0] loc_of(input logic [PW-1:0] p);
    logic [SW-1:0] strm;
    logic [CW-1:0] chan;
    strm = p[SW-1:0];
    chan = p[PW-1:SW] + CW'(LEAD);
    return {strm, chan};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_addr <= loc_of('0);
    else        rd_addr <= loc_of(pos_nxt);
  end
endmodule

// File: rtl/cbs_out_stage.sv
module cbs_out_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_bit,
  output logic ser_out
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ser_out <= 1'b0;
    else        ser_out <= rd_bit;
  end
endmodule

// File: rtl/ctrl_bit_serializer.sv
module ctrl_bit_serializer #(
  parameter int unsigned STREAMS  = cbs_pkg::DEF_STREAMS,
  parameter int unsigned CHANNELS = cbs_pkg::DEF_CHANNELS,
  parameter int unsigned LEAD     = cbs_pkg::DEF_LEAD
) (
  input  logic                                        clk,
  input  logic                                        rst_n,
  input  logic                                        frame_pulse,
  output logic [$clog2(STREAMS)+$clog2(CHANNELS)-1:0] rd_addr,
  input  logic                                        rd_bit,
  output logic                                        ser_out
);
  localparam int unsigned SW    = $clog2(STREAMS);
  localparam int unsigned CW    = $clog2(CHANNELS);
  localparam int unsigned PW    = SW + CW;
  localparam int unsigned SLOTS = STREAMS * CHANNELS;

  logic [PW-1:0] pos_q;
  logic [PW-1:0] pos_nxt;

  cbs_frame_counter #(.SLOTS(SLOTS), .PW(PW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .frame_pulse(frame_pulse),
    .pos_q(pos_q), .pos_nxt(pos_nxt)
  );

  cbs_addr_stage #(.STREAMS(STREAMS), .CHANNELS(CHANNELS), .LEAD(LEAD)) u_addr (
    .clk(clk), .rst_n(rst_n), .pos_nxt(pos_nxt), .rd_addr(rd_addr)
  );

  cbs_out_stage u_out (
    .clk(clk), .rst_n(rst_n), .rd_bit(rd_bit), .ser_out(ser_out)
  );

  // R3: address fields follow the position counter with a one-channel lead
  p_addr_map_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr[CW-1:0] == CW'(pos_q[PW-1:SW] + CW'(LEAD))) &&
    (rd_addr[PW-1:CW] == pos_q[SW-1:0]));

  // R4: location 0 at first clock of the last channel, location of stream 1 next
  p_loc0_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pos_q == PW'((CHANNELS - 1) * STREAMS)) |-> (rd_addr == '0));
  p_loc32_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pos_q == PW'((CHANNELS - 1) * STREAMS + 1)) |-> (rd_addr == PW'(CHANNELS)));

  // R2: a sampled frame pulse restarts at position 0
  p_frame_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(frame_pulse) |-> (pos_q == '0 && rd_addr == PW'(LEAD)));
endmodule

// File: tb/tb_ctrl_bit_serializer.sv
`timescale 1ns/1ps
module tb_ctrl_bit_serializer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frame_pulse = 1'b0;
  logic [8:0] rd_addr;
  logic       rd_bit;
  logic       ser_out;
  logic       mem [512];
  int         n_chk = 0;
  int         n_bad = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  assign rd_bit = mem[rd_addr];

  ctrl_bit_serializer dut (
    .clk(clk), .rst_n(rst_n), .frame_pulse(frame_pulse),
    .rd_addr(rd_addr), .rd_bit(rd_bit), .ser_out(ser_out)
  );

  function automatic int exp_addr(int p);
    return (p % 16) * 32 + ((p / 16) + 1) % 32;
  endfunction

  function automatic int exp_bit(int p);
    return int'(mem[exp_addr(p)]);
  endfunction

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic fill(int seed);
    logic [31:0] s = 32'(seed);
    for (int i = 0; i < 512; i++) begin
      s = s * 32'd1103515245 + 32'd12345;
      mem[i] = s[16];
    end
  endtask

  task automatic start_frame(string req);
    @(negedge clk) frame_pulse = 1'b1;
    @(negedge clk) frame_pulse = 1'b0;
    check(req, int'(rd_addr), 1);
  endtask

  // checks n consecutive positions starting at 'first'; optional aligned pulse
  task automatic run_checks(int first, int n, string req, int fp_at);
    for (int i = 0; i < n; i++) begin
      int p;
      @(negedge clk);
      p = (first + i) % 512;
      check(req, int'(ser_out), exp_bit(p));
      check(req, int'(rd_addr), exp_addr((p + 1) % 512));
      if (i == fp_at) frame_pulse = 1'b1;
      if (i == fp_at + 1) frame_pulse = 1'b0;
    end
  endtask

  task automatic t_reset_r1();
    fill(7);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", int'(ser_out), 0);
    check("R1", int'(rd_addr), 1);
    rst_n = 1'b1;
  endtask

  task automatic t_start_r2();
    fill(11);
    start_frame("R2");
    run_checks(0, 32, "R2", -1);
  endtask

  task automatic t_map_r3();
    fill(23);
    start_frame("R3");
    run_checks(0, 512, "R3", -1);
  endtask

  task automatic t_loc_r4();
    for (int i = 0; i < 512; i++) mem[i] = 1'b0;
    mem[0] = 1'b1;
    mem[32] = 1'b1;
    start_frame("R4");
    for (int p = 0; p < 512; p++) begin
      @(negedge clk);
      if (p == 495) check("R4", int'(rd_addr), 0);
      if (p == 496) check("R4", int'(rd_addr), 32);
      check("R4", int'(ser_out), (p == 496 || p == 497) ? 1 : 0);
    end
  endtask

  task automatic t_wrap_r5_r6();
    fill(97);
    start_frame("R5");
    run_checks(0, 1024, "R5 R6", -1);
  endtask

  task automatic t_midframe_r7();
    fill(131);
    start_frame("R7");
    run_checks(0, 100, "R7", -1);
    frame_pulse = 1'b1;
    @(negedge clk) frame_pulse = 1'b0;
    check("R7", int'(ser_out), exp_bit(100));
    check("R7", int'(rd_addr), 1);
    run_checks(0, 64, "R7", -1);
  endtask

  task automatic t_aligned_r8();
    fill(257);
    start_frame("R8");
    run_checks(0, 512, "R8", 510);
    run_checks(0, 64, "R8", -1);
  endtask

  initial begin
    t_reset_r1();
    t_start_r2();
    t_map_r3();
    t_loc_r4();
    t_wrap_r5_r6();
    t_midframe_r7();
    t_aligned_r8();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(100000 * 5);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule